// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block lets a clocked system read and write one external asynchronous static RAM of 128K bytes. On the user side a request is a one-cycle pulse. It carries a write flag, a 17-bit byte address and 8 bits of write data. The controller answers each request with a one-cycle acknowledge, and for a read it also returns the captured byte. It handles one transaction at a time. A request is accepted only while the controller is idle.

On the memory side the controller drives the address bus and two chip selects of opposite polarity. The device counts as selected only when the low-active select is 0 and the high-active select is 1. The controller also drives an output enable and a write enable, both active low. The bidirectional data bus is split into an outgoing byte, an incoming byte and a driver enable for the pad.

Every timing interval is a parameter counted in clock cycles, rounded up from the memory's nanosecond figures: read access, address setup, write-enable-to-driver turnaround, write pulse and data setup. A down-counter enforces each interval. All memory-side outputs come straight from flops.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high, and after it is released with no request pending, the outputs are parked: select pair deselected (`mem_ce_n`=1, `mem_ce`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `ack`=0.
- R2: A read (request with `req_wr`=0) selects the device with `mem_oe_n`=0 and `mem_we_n`=1 for RD_ACCESS_CYC cycles. On the last of these edges it captures `mem_dq_in` into `rdata`. `ack` is high in the cycle after that edge, so it is seen RD_ACCESS_CYC+1 rising edges after the edge that sampled the request.
- R3: A write (`req_wr`=1) selects the device for ADDR_SETUP_CYC cycles with `mem_we_n` high. It then holds `mem_we_n` low for TURN_CYC + max(DATA_SETUP_CYC, WE_PULSE_CYC-TURN_CYC, 1) cycles while selected, and `ack` is seen one cycle after the hold cycle. The byte driven during the low phase is the one stored.
- R4: `mem_oe_n` is high whenever `mem_we_n` is low. `mem_dq_oe` is never high while the memory may drive the bus (selected, `mem_oe_n` low, `mem_we_n` high).
- R5: `mem_dq_oe` stays low for the first TURN_CYC cycles after `mem_we_n` falls. It stays high, with the data steady, for at least DATA_SETUP_CYC cycles before `mem_we_n` rises and for one cycle after it rises.
- R6: `ack` is high for exactly one cycle per accepted transaction, and the device is deselected in that cycle.
- R7: A request raised while a transaction is in progress is ignored. It causes no extra acknowledge and no memory access.
- R8: `rdata` keeps its value until the next read completes; a write does not change it.
- R9: The address and the select pair are steady for the whole time the device is selected, at any address from 0 to 17'h1FFFF.
- R10: A request presented in the acknowledge cycle of the previous transaction is accepted at the next edge, with the same latency as from a quiet idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle transaction request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read |
| mem_addr | output | 17 | Memory address bus |
| mem_ce_n | output | 1 | Low-active chip select |
| mem_ce | output | 1 | High-active chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Byte for the data pads |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | 8 | Byte from the data pads |

## Verification
The acknowledge of one transaction and the acceptance of the next can fall in the same cycle, because the controller is already idle while `ack` is high. The bench provokes this by raising the next request at the very sample point where it sees `ack`, both in directed write-then-read pairs and in about half of the random operations. It then judges the overlap by the new transaction's latency, which must equal the quiet-idle latency. It also uses the data read back through a bench memory model, which enforces the select, pulse, setup and turnaround windows and flags any bus contention or address movement while the device is selected.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_ACC  = 3'd1,
        ST_WR_ASU  = 3'd2,
        ST_WR_TURN = 3'd3,
        ST_WR_DRV  = 3'd4,
        ST_WR_HOLD = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic oe_n;
        logic we_n;
        logic drive;
    } bus_ctl_t;

    function automatic bus_ctl_t ctl_for_state(input seq_state_e s);
        bus_ctl_t c;
        c = '{sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        case (s)
            ST_RD_ACC: begin
                c.sel_n = 1'b0; c.sel = 1'b1; c.oe_n = 1'b0;
            end
            ST_WR_ASU: begin
                c.sel_n = 1'b0; c.sel = 1'b1;
            end
            ST_WR_TURN: begin
                c.sel_n = 1'b0; c.sel = 1'b1; c.we_n = 1'b0;
            end
            ST_WR_DRV: begin
                c.sel_n = 1'b0; c.sel = 1'b1; c.we_n = 1'b0; c.drive = 1'b1;
            end
            ST_WR_HOLD: begin
                c.sel_n = 1'b0; c.sel = 1'b1; c.drive = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned span_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W    = 3,
    parameter int unsigned RD_LEN   = 4,
    parameter int unsigned ASU_LEN  = 1,
    parameter int unsigned TURN_LEN = 2,
    parameter int unsigned DRV_LEN  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_wr,
    input  logic             expired,
    output seq_state_e       state_d,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             accept,
    output logic             finish,
    output logic             capture
);
    seq_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        finish   = 1'b0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (req_wr) begin
                        state_d  = ST_WR_ASU;
                        load_val = CNT_W'(ASU_LEN - 1);
                    end else begin
                        state_d  = ST_RD_ACC;
                        load_val = CNT_W'(RD_LEN - 1);
                    end
                end
            end
            ST_RD_ACC: begin
                if (expired) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                    capture = 1'b1;
                end
            end
            ST_WR_ASU: begin
                if (expired) begin
                    state_d  = ST_WR_TURN;
                    load     = 1'b1;
                    load_val = CNT_W'(TURN_LEN - 1);
                end
            end
            ST_WR_TURN: begin
                if (expired) begin
                    state_d  = ST_WR_DRV;
                    load     = 1'b1;
                    load_val = CNT_W'(DRV_LEN - 1);
                end
            end
            ST_WR_DRV: begin
                if (expired) begin
                    state_d = ST_WR_HOLD;
                    load    = 1'b1;
                end
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
                finish  = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/sram_bus_path.sv
module sram_bus_path
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state_d,
    input  logic              accept,
    input  logic              finish,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    bus_ctl_t          ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= ctl_for_state(ST_IDLE);
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            ack_q   <= 1'b0;
        end else begin
            ctl_q <= ctl_for_state(state_d);
            ack_q <= finish;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) begin
                rdata_q <= mem_dq_in;
            end
        end
    end

    assign mem_addr   = addr_q;
    assign mem_ce_n   = ctl_q.sel_n;
    assign mem_ce     = ctl_q.sel;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_dq_oe  = ctl_q.drive;
    assign mem_dq_out = wdata_q;
    assign ack        = ack_q;
    assign rdata      = rdata_q;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W         = 17,
    parameter int unsigned DATA_W         = 8,
    parameter int unsigned RD_ACCESS_CYC  = 4,
    parameter int unsigned ADDR_SETUP_CYC = 1,
    parameter int unsigned WE_PULSE_CYC   = 3,
    parameter int unsigned DATA_SETUP_CYC = 2,
    parameter int unsigned TURN_CYC       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned PULSE_REST = (WE_PULSE_CYC > TURN_CYC) ? (WE_PULSE_CYC - TURN_CYC) : 1;
    localparam int unsigned DRV_CYC    = max_u(DATA_SETUP_CYC, PULSE_REST);
    localparam int unsigned LONGEST    = max_u(max_u(RD_ACCESS_CYC, ADDR_SETUP_CYC), max_u(TURN_CYC, DRV_CYC));
    localparam int unsigned CNT_W      = span_bits(LONGEST);

    seq_state_e       state_d;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic             accept;
    logic             finish;
    logic             capture;

    sram_interval_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sram_seq_fsm #(
        .CNT_W    (CNT_W),
        .RD_LEN   (RD_ACCESS_CYC),
        .ASU_LEN  (ADDR_SETUP_CYC),
        .TURN_LEN (TURN_CYC),
        .DRV_LEN  (DRV_CYC)
    ) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .req_wr   (req_wr),
        .expired  (expired),
        .state_d  (state_d),
        .load     (load),
        .load_val (load_val),
        .accept   (accept),
        .finish   (finish),
        .capture  (capture)
    );

    sram_bus_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) path_i (
        .clk        (clk),
        .rst        (rst),
        .state_d    (state_d),
        .accept     (accept),
        .finish     (finish),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_ce     (mem_ce),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .ack        (ack),
        .rdata      (rdata)
    );
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int unsigned ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);
    logic sel;
    assign sel = !mem_ce_n && mem_ce;

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst) ack |=> !ack); // R6
    AST_ACK_DESELECTED: assert property (@(posedge clk) disable iff (rst) ack |-> !sel); // R6
    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> mem_oe_n); // R4
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst) mem_dq_oe |-> mem_oe_n); // R4
    AST_WE_SELECTED: assert property (@(posedge clk) disable iff (rst) !mem_we_n |-> sel); // R3
    AST_TURN_FIRST: assert property (@(posedge clk) disable iff (rst) $fell(mem_we_n) |-> !mem_dq_oe); // R5
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst) $rose(mem_we_n) |-> mem_dq_oe); // R5
    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst) (sel && $past(sel)) |-> $stable(mem_addr)); // R9
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;
    localparam int RD   = 4;
    localparam int ASU  = 1;
    localparam int PW   = 3;
    localparam int DSU  = 2;
    localparam int TURN = 2;

    function automatic int exp_rd_lat();
        return RD + 1;
    endfunction
    function automatic int exp_wr_lat();
        int drv;
        drv = (PW > TURN) ? PW - TURN : 1;
        if (DSU > drv) drv = DSU;
        return ASU + TURN + drv + 2;
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ack;
    logic [7:0]  rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    always #2.5 clk = ~clk;

    sram_async_ctrl #(
        .RD_ACCESS_CYC(RD), .ADDR_SETUP_CYC(ASU), .WE_PULSE_CYC(PW),
        .DATA_SETUP_CYC(DSU), .TURN_CYC(TURN)
    ) dut_i (
        .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_chk = 0, n_fail = 0, n_ops = 0, n_acks = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory device model: minimum windows at 5 ns per cycle
    logic [7:0] mem_arr [logic [16:0]];
    logic [7:0] shadow  [logic [16:0]];
    int rd_cnt = 0, wl_cnt = 0, ds_cnt = 0;
    int cont_v = 0, turn_v = 0, wr_v = 0, addr_v = 0;
    logic prev_sel = 0, prev_we = 1, prev_drv = 0;
    logic [16:0] prev_addr = '0;
    logic [7:0]  prev_out = '0;

    function automatic logic [7:0] peek(input logic [16:0] a);
        return mem_arr.exists(a) ? mem_arr[a] : 8'h00;
    endfunction
    function automatic logic [7:0] exp_of(input logic [16:0] a);
        return shadow.exists(a) ? shadow[a] : 8'h00;
    endfunction

    always @(negedge clk) begin
        logic sel, rd_en;
        sel   = !mem_ce_n && mem_ce;
        rd_en = sel && !mem_oe_n && mem_we_n;
        if (ack) n_acks++;
        if (rd_en) begin
            if (rd_cnt > 0 && mem_addr == prev_addr) begin
                if (rd_cnt < 100) rd_cnt++;
            end else rd_cnt = 1;
        end else rd_cnt = 0;
        mem_dq_in = (rd_en && rd_cnt >= 3) ? peek(mem_addr) : 8'hEE;
        if (sel && prev_sel && mem_addr != prev_addr) addr_v++;
        if (mem_dq_oe && rd_en) cont_v++;
        if (!mem_we_n && !mem_oe_n) cont_v++;
        if (!mem_we_n) begin
            wl_cnt++;
            if (mem_dq_oe) begin
                if (prev_drv && mem_dq_out == prev_out) ds_cnt++;
                else ds_cnt = 1;
                if (wl_cnt <= 2) turn_v++;
            end else ds_cnt = 0;
        end else if (!prev_we) begin
            if (sel && wl_cnt >= 3 && ds_cnt >= 2 && mem_dq_oe && mem_dq_out == prev_out)
                mem_arr[mem_addr] = mem_dq_out;
            else wr_v++;
            wl_cnt = 0;
            ds_cnt = 0;
        end
        prev_sel  = sel;
        prev_we   = mem_we_n;
        prev_drv  = mem_dq_oe;
        prev_out  = mem_dq_out;
        prev_addr = mem_addr;
    end

    // Called at a negedge; returns at the negedge where ack is seen
    task automatic run_op(input bit wr, input logic [16:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int lat);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            req = 1'b0;
        end while (!ack && lat < 100);
        rd = rdata;
        n_ops++;
        if (wr) shadow[a] = d;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, held;
        int lat;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe && !ack, "R1 reset",
            {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe, ack}, 6'b101100);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe && !ack, "R1 idle",
            {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe, ack}, 6'b101100);

        // R3 / R9 corner addresses and data
        run_op(1'b1, 17'h00000, 8'hFF, rd, lat);
        chk(lat == exp_wr_lat(), "R3 write latency", lat, exp_wr_lat());
        run_op(1'b1, 17'h1FFFF, 8'h00, rd, lat);
        run_op(1'b1, 17'h1FFFE, 8'hA5, rd, lat);
        // R10 read issued in the ack cycle of the write
        run_op(1'b0, 17'h1FFFE, 8'h00, rd, lat);
        chk(lat == exp_rd_lat(), "R10 back-to-back read latency", lat, exp_rd_lat());
        chk(rd == 8'hA5, "R2 read after write", rd, 8'hA5);
        run_op(1'b0, 17'h00000, 8'h00, rd, lat);
        chk(rd == 8'hFF, "R9 address 0", rd, 8'hFF);
        run_op(1'b0, 17'h1FFFF, 8'h00, rd, lat);
        chk(rd == 8'h00, "R9 address 1FFFF", rd, 8'h00);

        // R8 rdata held across a write
        run_op(1'b0, 17'h00000, 8'h00, held, lat);
        run_op(1'b1, 17'h00123, 8'h5A, rd, lat);
        chk(rdata == held, "R8 rdata held", rdata, held);

        // R7 requests during a busy write are ignored
        req = 1'b1; req_wr = 1'b1; req_addr = 17'h00055; req_wdata = 8'h3C;
        @(posedge clk); @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 17'h00055; req_wdata = 8'hC3;
        @(negedge clk);
        req_wr = 1'b0; req_addr = 17'h00123;
        @(negedge clk);
        req = 1'b0;
        lat = 0;
        while (!ack && lat < 100) begin @(negedge clk); lat++; end
        n_ops++;
        shadow[17'h00055] = 8'h3C;
        repeat (3) @(negedge clk);
        chk(n_acks == n_ops, "R7 no extra ack", n_acks, n_ops);
        run_op(1'b0, 17'h00055, 8'h00, rd, lat);
        chk(rd == 8'h3C, "R7 busy write ignored", rd, 8'h3C);

        // Random mix: R2 R3 R10
        for (int i = 0; i < 300; i++) begin
            bit wr;
            logic [16:0] a;
            logic [7:0] d;
            wr = $urandom % 2;
            a  = ($urandom % 2) ? (17'h1FFF0 + 17'($urandom % 16)) : 17'($urandom % 16);
            d  = 8'($urandom);
            if ($urandom % 2) repeat (1 + $urandom % 3) @(negedge clk);
            if (wr) begin
                run_op(1'b1, a, d, rd, lat);
                chk(lat == exp_wr_lat(), "R3 random write latency", lat, exp_wr_lat());
            end else begin
                d = exp_of(a);
                run_op(1'b0, a, 8'h00, rd, lat);
                chk(lat == exp_rd_lat(), "R2 random read latency", lat, exp_rd_lat());
                chk(rd == d, "R2 random read data", rd, d);
            end
        end

        repeat (3) @(negedge clk);
        chk(n_acks == n_ops, "R6 one ack per transaction", n_acks, n_ops);
        chk(cont_v == 0, "R4 bus contention", cont_v, 0);
        chk(turn_v == 0, "R5 turnaround", turn_v, 0);
        chk(wr_v == 0, "R5 write pulse/setup/hold", wr_v, 0);
        chk(addr_v == 0, "R9 address steady while selected", addr_v, 0);
        chk(mem_ce_n && !mem_ce && !mem_dq_oe, "R6 parked after last ack",
            {mem_ce_n, mem_ce, mem_dq_oe}, 3'b100);
        done = 1;
        summary();
        $finish;
    end
endmodule